// File: doc/BRIEF.md
# Overlap-Save Segment Buffer Controller

This block collects the complex baseband samples of one chirp into a 1024-entry segment buffer and cuts a long chirp into overlapping segments for a fast-convolution engine that sits outside the block. Each new segment after the first keeps the 128-sample tail of the previous one at the front of the buffer. It then takes in only the fresh samples that follow. Any part of the buffer that the chirp leaves unfilled is set to zero. This applies to the final partial segment of a long chirp and to a short chirp.

For each segment the block fetches the matching reference waveform from an external memory, one word per buffer position, over a request/ready handshake. It sends every buffered sample together with its reference word to the engine. It then passes the engine's 1024 results per segment to its output. A chirp begins only on a rising edge of the start strobe. A 4-bit status output shows the current state.

Top module: `ovsSegmentCtrl`

## Requirements
- R1: After reset, status reads 0 (idle), and refReq, engInValid and outValid are all low.
- R2: While idle, valid input samples are ignored and the state stays idle. A chirp begins only when chirpStart goes from 0 to 1, and the state then moves to collect.
- R3: Each stored sample keeps the upper 16 bits of the 18-bit input. The two LSBs are dropped. I and Q are stored separately.
- R4: The first segment of a long chirp (longMode=1) takes 1024 fresh samples into positions 0..1023. The reference fetch begins in the cycle after the last of these samples is accepted, and status reads 3 at that point.
- R5: Before each later segment, buffer positions 896..1023 are copied to positions 0..127. The next fresh samples fill the buffer from position 128 onward.
- R6: A long chirp is 3000 samples in 4 segments that take 1024, 896, 896 and 184 fresh samples. After the last of these samples, status reads 2 (zero fill), and positions 312..1023 of the final segment hold zero.
- R7: A short chirp (longMode=0) is one segment of 50 samples. Positions 50..1023 hold zero, and status reads 2 right after the 50th sample.
- R8: Each segment produces exactly 1024 outValid results, which are the engine results in arrival order. After the last segment, status returns to 0.
- R9: The block issues one reference request per buffer position, in ascending refAddr order 0..1023. refSegment carries the segment index. A new request waits for refReady, and the engine receives each sample together with the reference word that arrived with refReady.
- R10: The status encoding is 0 idle, 1 collect, 2 zero fill, 3 reference request, 4 reference wait, 5 engine wait, 6 output, 7 overlap copy.
- R11: A chirpStart rising edge during a chirp is ignored. When chirpStart is held high at the end of a chirp, no new chirp starts. The strobe must go low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inI | input | 18 | Input sample, in-phase |
| inQ | input | 18 | Input sample, quadrature |
| inValid | input | 1 | Input sample strobe |
| chirpStart | input | 1 | Chirp start level; its rising edge starts a chirp |
| longMode | input | 1 | 1 selects long chirp, 0 short chirp; latched at start |
| refSegment | output | 2 | Segment index of the reference fetch |
| refAddr | output | 10 | Sample address of the reference fetch |
| refReq | output | 1 | Reference fetch request |
| refReady | input | 1 | Reference word valid |
| refRe | input | 16 | Reference word, real part |
| refIm | input | 16 | Reference word, imaginary part |
| engSampleRe | output | 16 | Buffered sample to engine, real |
| engSampleIm | output | 16 | Buffered sample to engine, imaginary |
| engRefRe | output | 16 | Reference word to engine, real |
| engRefIm | output | 16 | Reference word to engine, imaginary |
| engInValid | output | 1 | Engine input strobe |
| engResRe | input | 16 | Engine result, real |
| engResIm | input | 16 | Engine result, imaginary |
| engResValid | input | 1 | Engine result strobe |
| outRe | output | 16 | Result out, real |
| outIm | output | 16 | Result out, imaginary |
| outValid | output | 1 | Result out strobe |
| status | output | 4 | Current state code (R10) |

## Verification
The assertions assume that refReady comes only in answer to a request, and that the engine sends no result while the block is still feeding it. The bench reference model raises refReady exactly one cycle after each refReq. The engine stub keeps all 1024 inputs of a segment before it replays them as results. Result data is each stored sample XORed with its reference word, so one comparison checks truncation, overlap, zero fill and reference addressing together. Inputs change only on falling edges, and a chirp's samples are driven only after status shows collect.

// File: rtl/ovsPkg.sv
package ovsPkg;
  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_COLLECT = 4'd1,
    ST_ZPAD    = 4'd2,
    ST_WREF    = 4'd3,
    ST_PROC    = 4'd4,
    ST_WENG    = 4'd5,
    ST_OUT     = 4'd6,
    ST_NEXT    = 4'd7
  } ovsState_e;

  typedef struct packed {
    logic wrSample;
    logic wrZero;
    logic copyStep;
    logic feed;
    logic pass;
  } ovsStrobe_t;
endpackage

// File: rtl/ovsControl.sv
module ovsControl import ovsPkg::*; #(
  parameter int SEG_LEN   = 1024,
  parameter int OVERLAP   = 128,
  parameter int LONG_LEN  = 3000,
  parameter int SHORT_LEN = 50,
  parameter int LONG_SEGS = 4,
  localparam int AW    = $clog2(SEG_LEN),
  localparam int SEG_W = $clog2(LONG_SEGS),
  localparam int CNT_W = $clog2(LONG_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             chirpStart,
  input  logic             longMode,
  input  logic             refReady,
  input  logic             engResValid,
  output ovsStrobe_t       strobe,
  output logic [AW-1:0]    addr,
  output logic             refReq,
  output logic [SEG_W-1:0] segIdx,
  output ovsState_e        state
);
  localparam logic [AW-1:0] LAST_POS = AW'(SEG_LEN - 1);
  localparam logic [AW-1:0] OV_LAST  = AW'(OVERLAP - 1);
  localparam logic [AW-1:0] OV_START = AW'(OVERLAP);

  ovsState_e        st;
  logic             startPrev, isLong;
  logic [AW-1:0]    wPtr, rPtr, oCnt, cIdx;
  logic [SEG_W-1:0] seg;
  logic [CNT_W-1:0] taken, chirpLen;
  logic [SEG_W-1:0] segLast;
  logic             chirpDone, startRise;

  assign chirpLen  = isLong ? CNT_W'(LONG_LEN) : CNT_W'(SHORT_LEN);
  assign segLast   = isLong ? SEG_W'(LONG_SEGS - 1) : '0;
  assign chirpDone = (taken == chirpLen);
  assign startRise = chirpStart & ~startPrev;

  always_comb begin
    strobe          = '0;
    strobe.wrSample = (st == ST_COLLECT) && inValid && !chirpDone;
    strobe.wrZero   = (st == ST_ZPAD);
    strobe.copyStep = (st == ST_NEXT);
    strobe.feed     = (st == ST_PROC) && refReady;
    strobe.pass     = ((st == ST_WENG) || (st == ST_OUT)) && engResValid;
    case (st)
      ST_COLLECT, ST_ZPAD: addr = wPtr;
      ST_NEXT:             addr = cIdx;
      default:             addr = rPtr;
    endcase
  end

  assign refReq = (st == ST_WREF);
  assign segIdx = seg;
  assign state  = st;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st <= ST_IDLE;  startPrev <= 1'b0;  isLong <= 1'b0;
      wPtr <= '0;  rPtr <= '0;  oCnt <= '0;  cIdx <= '0;
      seg <= '0;  taken <= '0;
    end else begin
      startPrev <= chirpStart;
      case (st)
        ST_IDLE: if (startRise) begin
          st <= ST_COLLECT;  wPtr <= '0;  seg <= '0;
          taken <= '0;  isLong <= longMode;
        end
        ST_COLLECT: begin
          if (chirpDone) st <= ST_ZPAD;
          else if (inValid) begin
            wPtr  <= wPtr + 1'b1;
            taken <= taken + 1'b1;
            if (wPtr == LAST_POS) begin
              st <= ST_WREF;  rPtr <= '0;
            end else if (taken + CNT_W'(1) == chirpLen) st <= ST_ZPAD;
          end
        end
        ST_ZPAD: begin
          wPtr <= wPtr + 1'b1;
          if (wPtr == LAST_POS) begin
            st <= ST_WREF;  rPtr <= '0;
          end
        end
        ST_WREF: st <= ST_PROC;
        ST_PROC: if (refReady) begin
          rPtr <= rPtr + 1'b1;
          if (rPtr == LAST_POS) begin
            st <= ST_WENG;  oCnt <= '0;
          end else st <= ST_WREF;
        end
        ST_WENG: if (engResValid) begin
          oCnt <= AW'(1);  st <= ST_OUT;
        end
        ST_OUT: if (engResValid) begin
          oCnt <= oCnt + 1'b1;
          if (oCnt == LAST_POS) begin
            if (seg == segLast) st <= ST_IDLE;
            else begin
              st <= ST_NEXT;  cIdx <= '0;
            end
          end
        end
        ST_NEXT: begin
          cIdx <= cIdx + 1'b1;
          if (cIdx == OV_LAST) begin
            st <= ST_COLLECT;  seg <= seg + 1'b1;  wPtr <= OV_START;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ovsDatapath.sv
module ovsDatapath import ovsPkg::*; #(
  parameter int SEG_LEN = 1024,
  parameter int OVERLAP = 128,
  parameter int IN_W    = 18,
  parameter int SMP_W   = 16,
  localparam int AW     = $clog2(SEG_LEN),
  localparam int DROP   = IN_W - SMP_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  ovsStrobe_t       strobe,
  input  logic [AW-1:0]    addr,
  input  logic [IN_W-1:0]  inI,
  input  logic [IN_W-1:0]  inQ,
  input  logic [SMP_W-1:0] refRe,
  input  logic [SMP_W-1:0] refIm,
  input  logic [SMP_W-1:0] engResRe,
  input  logic [SMP_W-1:0] engResIm,
  output logic [SMP_W-1:0] engSampleRe,
  output logic [SMP_W-1:0] engSampleIm,
  output logic [SMP_W-1:0] engRefRe,
  output logic [SMP_W-1:0] engRefIm,
  output logic             engInValid,
  output logic [SMP_W-1:0] outRe,
  output logic [SMP_W-1:0] outIm,
  output logic             outValid
);
  localparam logic [AW-1:0] TAIL_OFS = AW'(SEG_LEN - OVERLAP);

  logic [2*SMP_W-1:0] bufMem [SEG_LEN];
  logic [2*SMP_W-1:0] rdWord, tailWord;
  logic               unusedLsbs;

  assign rdWord     = bufMem[addr];
  assign tailWord   = bufMem[addr + TAIL_OFS];
  assign unusedLsbs = ^{inI[DROP-1:0], inQ[DROP-1:0]};

  always_ff @(posedge clk) begin
    if (strobe.wrSample)      bufMem[addr] <= {inI[IN_W-1 -: SMP_W], inQ[IN_W-1 -: SMP_W]};
    else if (strobe.wrZero)   bufMem[addr] <= '0;
    else if (strobe.copyStep) bufMem[addr] <= tailWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      engInValid <= 1'b0;  outValid <= 1'b0;
      engSampleRe <= '0;  engSampleIm <= '0;  engRefRe <= '0;  engRefIm <= '0;
      outRe <= '0;  outIm <= '0;
    end else begin
      engInValid <= strobe.feed;
      outValid   <= strobe.pass;
      if (strobe.feed) begin
        engSampleRe <= rdWord[2*SMP_W-1 -: SMP_W];
        engSampleIm <= rdWord[SMP_W-1:0];
        engRefRe    <= refRe;
        engRefIm    <= refIm;
      end
      if (strobe.pass) begin
        outRe <= engResRe;
        outIm <= engResIm;
      end
    end
  end
endmodule

// File: rtl/ovsSegmentCtrl.sv
module ovsSegmentCtrl import ovsPkg::*; #(
  parameter int SEG_LEN   = 1024,
  parameter int OVERLAP   = 128,
  parameter int LONG_LEN  = 3000,
  parameter int SHORT_LEN = 50,
  parameter int LONG_SEGS = 4,
  parameter int IN_W      = 18,
  parameter int SMP_W     = 16,
  localparam int AW       = $clog2(SEG_LEN),
  localparam int SEG_W    = $clog2(LONG_SEGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IN_W-1:0]  inI,
  input  logic [IN_W-1:0]  inQ,
  input  logic             inValid,
  input  logic             chirpStart,
  input  logic             longMode,
  output logic [SEG_W-1:0] refSegment,
  output logic [AW-1:0]    refAddr,
  output logic             refReq,
  input  logic             refReady,
  input  logic [SMP_W-1:0] refRe,
  input  logic [SMP_W-1:0] refIm,
  output logic [SMP_W-1:0] engSampleRe,
  output logic [SMP_W-1:0] engSampleIm,
  output logic [SMP_W-1:0] engRefRe,
  output logic [SMP_W-1:0] engRefIm,
  output logic             engInValid,
  input  logic [SMP_W-1:0] engResRe,
  input  logic [SMP_W-1:0] engResIm,
  input  logic             engResValid,
  output logic [SMP_W-1:0] outRe,
  output logic [SMP_W-1:0] outIm,
  output logic             outValid,
  output logic [3:0]       status
);
  ovsStrobe_t    strobe;
  logic [AW-1:0] addr;
  ovsState_e     state;

  ovsControl #(.SEG_LEN(SEG_LEN), .OVERLAP(OVERLAP), .LONG_LEN(LONG_LEN),
               .SHORT_LEN(SHORT_LEN), .LONG_SEGS(LONG_SEGS)) uCtl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .chirpStart(chirpStart),
    .longMode(longMode), .refReady(refReady), .engResValid(engResValid),
    .strobe(strobe), .addr(addr), .refReq(refReq), .segIdx(refSegment),
    .state(state));

  ovsDatapath #(.SEG_LEN(SEG_LEN), .OVERLAP(OVERLAP), .IN_W(IN_W), .SMP_W(SMP_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr), .inI(inI), .inQ(inQ),
    .refRe(refRe), .refIm(refIm), .engResRe(engResRe), .engResIm(engResIm),
    .engSampleRe(engSampleRe), .engSampleIm(engSampleIm), .engRefRe(engRefRe),
    .engRefIm(engRefIm), .engInValid(engInValid), .outRe(outRe), .outIm(outIm),
    .outValid(outValid));

  assign refAddr = addr;
  assign status  = state;
endmodule

// File: rtl/ovsSegmentChk.sv
module ovsSegmentChk (
  input logic       clk,
  input logic       rstN,
  input logic       chirpStart,
  input logic [3:0] status,
  input logic       refReq,
  input logic       refReady,
  input logic       engInValid,
  input logic       outValid
);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status == 4'd0 && !chirpStart) |=> (status == 4'd0));

  // R2
  start_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status == 4'd1 && $past(status) == 4'd0) |-> $past(chirpStart));

  // R9
  req_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    refReq |=> !refReq);

  // R9
  feed_after_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    engInValid |-> $past(refReady));

  // R8
  out_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($past(status) == 4'd5 || $past(status) == 4'd6));
endmodule

bind ovsSegmentCtrl ovsSegmentChk uChk (
  .clk(clk), .rstN(rstN), .chirpStart(chirpStart), .status(status),
  .refReq(refReq), .refReady(refReady), .engInValid(engInValid),
  .outValid(outValid));

// File: tb/tb_ovsSegmentCtrl.sv
module tb_ovsSegmentCtrl;
  localparam int CLK_PERIOD = 10;
  localparam int SEG = 1024;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [17:0] inI = '0, inQ = '0;
  logic inValid = 1'b0, chirpStart = 1'b0, longMode = 1'b0;
  logic [1:0] refSegment;
  logic [9:0] refAddr;
  logic refReq;
  logic refReady = 1'b0;
  logic [15:0] refRe = '0, refIm = '0;
  logic [15:0] engSampleRe, engSampleIm, engRefRe, engRefIm;
  logic engInValid;
  logic [15:0] engResRe = '0, engResIm = '0;
  logic engResValid = 1'b0;
  logic [15:0] outRe, outIm;
  logic outValid;
  logic [3:0] status;

  ovsSegmentCtrl dut (
    .clk(clk), .rstN(rstN), .inI(inI), .inQ(inQ), .inValid(inValid),
    .chirpStart(chirpStart), .longMode(longMode), .refSegment(refSegment),
    .refAddr(refAddr), .refReq(refReq), .refReady(refReady), .refRe(refRe),
    .refIm(refIm), .engSampleRe(engSampleRe), .engSampleIm(engSampleIm),
    .engRefRe(engRefRe), .engRefIm(engRefIm), .engInValid(engInValid),
    .engResRe(engResRe), .engResIm(engResIm), .engResValid(engResValid),
    .outRe(outRe), .outIm(outIm), .outValid(outValid), .status(status));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int nextSmp = 0, wrPos = 0;
  int capCnt = 0, reqIdx = 0, reqErr = 0, expSeg = 0;
  logic [15:0] expRe [SEG];
  logic [15:0] expIm [SEG];
  logic [15:0] capRe [SEG];
  logic [15:0] capIm [SEG];

  // reference memory: ready one cycle after request; long mode word = {segment, address}
  always @(posedge clk) begin
    refReady <= rstN && refReq;
    if (refReq) begin
      refRe <= {4'hA, (longMode ? refSegment : 2'b00), refAddr};
      refIm <= {4'h5, refAddr, (longMode ? refSegment : 2'b00)};
    end
  end

  // engine stub: keep one segment of inputs, then replay sample^ref one per cycle
  logic [15:0] stRe [SEG];
  logic [15:0] stIm [SEG];
  int stCnt = 0, pIdx = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      stCnt <= 0;  pIdx <= 0;  engResValid <= 1'b0;
    end else begin
      engResValid <= 1'b0;
      if (stCnt < SEG) begin
        if (engInValid) begin
          stRe[stCnt] <= engSampleRe ^ engRefRe;
          stIm[stCnt] <= engSampleIm ^ engRefIm;
          stCnt <= stCnt + 1;
        end
      end else begin
        engResValid <= 1'b1;
        engResRe <= stRe[pIdx];
        engResIm <= stIm[pIdx];
        if (pIdx == SEG - 1) begin
          pIdx <= 0;  stCnt <= 0;
        end else pIdx <= pIdx + 1;
      end
    end
  end

  // monitors
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (capCnt < SEG) begin
        capRe[capCnt] = outRe;  capIm[capCnt] = outIm;
      end
      capCnt = capCnt + 1;
    end
    if (rstN && refReq) begin
      if (int'(refAddr) != (reqIdx % SEG) || int'(refSegment) != expSeg) reqErr = reqErr + 1;
      reqIdx = reqIdx + 1;
    end
  end

  task automatic checkEq(string tag, int act, int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] sI(int n);
    return 18'((n * 613 + 77) ^ (n << 5));
  endfunction
  function automatic logic [17:0] sQ(int n);
    return 18'((n * 229 + 1001) ^ 18'h2A5A5);
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;  inValid = 1'b0;  chirpStart = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitStatus(int code);
    int t = 0;
    while (int'(status) != code && t < 20000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic feedN(int count);
    for (int i = 0; i < count; i++) begin
      @(negedge clk);
      inI = sI(nextSmp);  inQ = sQ(nextSmp);  inValid = 1'b1;
      expRe[wrPos] = sI(nextSmp) >> 2;
      expIm[wrPos] = sQ(nextSmp) >> 2;
      wrPos++;  nextSmp++;
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic collectSegment(string tag, int s);
    int t = 0;
    int bad = 0;
    int firstBad = -1;
    logic [15:0] eR, eI;
    while (capCnt < SEG && t < 30000) begin
      @(negedge clk);
      t++;
    end
    repeat (8) @(negedge clk);
    checkEq({tag, " R8 result count"}, capCnt, SEG);
    for (int k = 0; k < SEG; k++) begin
      eR = expRe[k] ^ {4'hA, 2'(s), 10'(k)};
      eI = expIm[k] ^ {4'h5, 10'(k), 2'(s)};
      if (capRe[k] != eR || capIm[k] != eI) begin
        bad++;
        if (firstBad < 0) firstBad = k;
      end
    end
    if (firstBad >= 0)
      $display("  first bad position %0d: got %h/%h", firstBad, capRe[firstBad], capIm[firstBad]);
    checkEq({tag, " R3 R9 result data mismatches"}, bad, 0);
  endtask

  task automatic testReset();
    doReset();
    checkEq("R1 status after reset", int'(status), 0);
    checkEq("R1 strobes after reset", int'({refReq, engInValid, outValid}), 0);
  endtask

  task automatic testShort();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      inI = 18'h3FFFF;  inQ = 18'h12345;  inValid = 1'b1;
    end
    @(negedge clk);
    inValid = 1'b0;
    checkEq("R2 idle ignores valid", int'(status), 0);
    checkEq("R2 no activity while idle", capCnt + reqIdx, 0);
    longMode = 1'b0;  expSeg = 0;  reqErr = 0;  reqIdx = 0;  capCnt = 0;
    chirpStart = 1'b1;
    @(negedge clk);
    checkEq("R2 R10 rising edge enters collect", int'(status), 1);
    wrPos = 0;
    feedN(50);
    checkEq("R7 R10 zero fill after 50 samples", int'(status), 2);
    for (int k = 50; k < SEG; k++) begin
      expRe[k] = '0;  expIm[k] = '0;
    end
    collectSegment("R7 short", 0);
    checkEq("R8 short back to idle", int'(status), 0);
    checkEq("R9 short request count", reqIdx, SEG);
    checkEq("R9 short request order", reqErr, 0);
    repeat (10) @(negedge clk);
    checkEq("R11 held start does not restart", int'(status), 0);
    chirpStart = 1'b0;
    @(negedge clk);
    chirpStart = 1'b1;
    @(negedge clk);
    checkEq("R11 low then high restarts", int'(status), 1);
  endtask

  task automatic testLong();
    int fresh;
    longMode = 1'b1;  reqIdx = 0;  reqErr = 0;
    chirpStart = 1'b0;
    @(negedge clk);
    chirpStart = 1'b1;
    @(negedge clk);
    checkEq("R2 long start enters collect", int'(status), 1);
    for (int s = 0; s < 4; s++) begin
      waitStatus(1);
      if (s > 0) begin
        for (int k = 0; k < 128; k++) begin
          expRe[k] = expRe[896 + k];  expIm[k] = expIm[896 + k];
        end
      end
      wrPos = (s == 0) ? 0 : 128;
      fresh = (s == 0) ? 1024 : ((s < 3) ? 896 : 184);
      expSeg = s;  capCnt = 0;
      feedN(fresh);
      if (s == 0) checkEq("R4 fetch starts after 1024 samples", int'(status), 3);
      if (s == 1) begin
        checkEq("R5 full after 896 fresh", int'(status), 3);
        chirpStart = 1'b0;
        @(negedge clk);
        chirpStart = 1'b1;
      end
      if (s == 3) begin
        checkEq("R6 R10 zero fill after 184 samples", int'(status), 2);
        for (int k = 312; k < SEG; k++) begin
          expRe[k] = '0;  expIm[k] = '0;
        end
      end
      collectSegment($sformatf("R5 R6 long seg %0d", s), s);
    end
    checkEq("R8 long back to idle", int'(status), 0);
    checkEq("R9 long request count", reqIdx, 4 * SEG);
    checkEq("R9 long request order and segment", reqErr, 0);
    repeat (20) @(negedge clk);
    checkEq("R11 mid-chirp edge ignored, held high no restart", int'(status), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks = checks + 1;  fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    testReset();
    testShort();
    doReset();
    testLong();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule